// File: doc/BRIEF.md
# Write-Sequence Feature Unlock Detector

This block watches the byte stream written to one I/O register and looks for a fixed key pattern. The pattern is armed by a short preamble: any number of nonzero bytes, then a zero. After that come fourteen fixed key bytes. If the fifteenth byte after the preamble is the open byte 0xEE, the lock opens. If the fourteen key bytes are followed by any other byte, the lock closes. The result is one status bit, `unlocked`. Neighbouring blocks use it to decide whether the extended registers (such as a secondary ROM page map) can be reached at all.

The host qualifies each byte with `wr_en`. The block takes a byte on every clock edge where `wr_en` is high and never back-pressures, so the input has no ready signal. Address decoding of the monitored register belongs to the surrounding logic, and so do the gated registers.

Top module: `seq_unlock_detect`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) forces `unlocked` to 0 and puts the matcher into its hunting state. A key run sent right after reset without a preamble therefore has no effect.
- R2: The matcher arms only on a nonzero byte followed directly by 0x00. Key bytes and 0xEE written without that preamble leave `unlocked` unchanged.
- R3: After the preamble, the key bytes 0xFF, 0x77, 0xB3, 0x51, 0xA8, 0xD4, 0x62, 0x39, 0x9C, 0x46, 0x2B, 0x15, 0x8A, 0xCD in that order, followed by 0xEE, set `unlocked` to 1. The change is visible after the clock edge that takes the 0xEE write.
- R4: After the preamble and the fourteen key bytes, any byte other than 0xEE clears `unlocked` to 0 on the edge that takes it.
- R5: A byte that breaks the key order before the fourteenth key byte aborts the match and leaves `unlocked` unchanged.
- R6: A 0x00 byte that arrives after a nonzero byte, including in the middle of a key run, re-arms the matcher at once. The next byte is then compared with the first key byte.
- R7: The non-0xEE byte that closes the lock is itself re-evaluated as a preamble byte. A 0x00 there arms the matcher immediately.
- R8: Clock edges with `wr_en` low change neither `unlocked` nor the matcher position.
- R9: A 0x00 byte that follows another 0x00 does not arm the matcher. The matcher drops back to hunting.
- R10: Any number of nonzero bytes may precede the preamble zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the monitored register; one byte per high cycle |
| wr_data | input | 8 | Byte written to the monitored register |
| unlocked | output | 1 | 1 while the enhanced features are open |

## Verification
The byte stream is tried in several forms, and each one separates a different fault.
- A clean preamble, key run and 0xEE shows that the order and the open byte are recognised.
- The same run ending in a stray byte shows that the close path works, and that the closing byte is re-read as a new preamble.
- A key run with no preamble tells an armed matcher apart from one that never left hunting.
- A wrong byte in mid-run checks that an abort does not move the lock.
- A zero in mid-run checks immediate re-arming.
- A double zero after the nonzero byte checks that the zero must follow a nonzero byte.
- Long nonzero prefixes and idle cycles with `wr_en` low show that unqualified edges are ignored.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
  localparam int UK_DW    = 8;
  localparam int UK_LEN   = 14;
  localparam int UK_IDX_W = $clog2(UK_LEN + 1);
  localparam logic [UK_DW-1:0] UK_OPEN = 8'hEE;

  typedef enum logic [1:0] {
    TRK_HUNT   = 2'd0,
    TRK_PRIMED = 2'd1,
    TRK_MATCH  = 2'd2
  } trk_state_e;

  // Expected byte at each slot; slot UK_LEN holds the open byte.
  function automatic logic [UK_DW-1:0] key_byte(input int slot);
    case (slot)
      0:  key_byte = 8'hFF;
      1:  key_byte = 8'h77;
      2:  key_byte = 8'hB3;
      3:  key_byte = 8'h51;
      4:  key_byte = 8'hA8;
      5:  key_byte = 8'hD4;
      6:  key_byte = 8'h62;
      7:  key_byte = 8'h39;
      8:  key_byte = 8'h9C;
      9:  key_byte = 8'h46;
      10: key_byte = 8'h2B;
      11: key_byte = 8'h15;
      12: key_byte = 8'h8A;
      13: key_byte = 8'hCD;
      14: key_byte = UK_OPEN;
      default: key_byte = '0;
    endcase
  endfunction
endpackage

// File: rtl/ulk_key_rom.sv
module ulk_key_rom
  import ulk_pkg::*;
(
  input  logic [UK_IDX_W-1:0] slot,
  input  logic [UK_DW-1:0]    byte_in,
  output logic                hit
);
  localparam int DEPTH = 2 ** UK_IDX_W;

  logic [UK_DW-1:0] tbl [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      if (g <= UK_LEN) begin : g_used
        assign tbl[g] = key_byte(g);
      end else begin : g_spare
        assign tbl[g] = '0;
      end
    end
  endgenerate

  // Spare slots hold zero, which never matches since the matcher never reaches them.
  assign hit = (byte_in == tbl[slot]) && (slot <= UK_IDX_W'(UK_LEN));
endmodule

// File: rtl/ulk_tracker.sv
module ulk_tracker
  import ulk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [UK_DW-1:0]    wr_data,
  input  logic                hit,
  output logic [UK_IDX_W-1:0] slot,
  output logic                open_p,
  output logic                close_p
);
  localparam logic [UK_IDX_W-1:0] LAST = UK_IDX_W'(UK_LEN);

  trk_state_e st_q, st_d;
  logic [UK_IDX_W-1:0] idx_q, idx_d;
  logic nz;

  assign nz   = |wr_data;
  assign slot = idx_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    open_p  = 1'b0;
    close_p = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        TRK_HUNT: begin
          if (nz) st_d = TRK_PRIMED;
        end
        TRK_PRIMED: begin
          if (!nz) begin
            st_d  = TRK_MATCH;
            idx_d = '0;
          end
        end
        TRK_MATCH: begin
          if (hit && idx_q != LAST) begin
            idx_d = idx_q + UK_IDX_W'(1);
          end else begin
            if (idx_q == LAST) begin
              open_p  = hit;
              close_p = !hit;
            end
            // Re-read the byte as a possible preamble start.
            // Slot 0 means the byte before was the preamble zero.
            if (nz) begin
              st_d = TRK_PRIMED;
            end else if (idx_q != '0) begin
              st_d  = TRK_MATCH;
              idx_d = '0;
            end else begin
              st_d = TRK_HUNT;
            end
          end
        end
        default: st_d = TRK_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TRK_HUNT;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/ulk_lock_flag.sv
module ulk_lock_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic open_p,
  input  logic close_p,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (open_p)  q <= 1'b1;
    else if (close_p) q <= 1'b0;
  end
endmodule

// File: rtl/seq_unlock_detect.sv
module seq_unlock_detect
  import ulk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [UK_DW-1:0] wr_data,
  output logic             unlocked
);
  logic [UK_IDX_W-1:0] slot;
  logic hit, open_p, close_p;

  ulk_key_rom u_rom (
    .slot(slot), .byte_in(wr_data), .hit(hit)
  );

  ulk_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hit(hit), .slot(slot), .open_p(open_p), .close_p(close_p)
  );

  ulk_lock_flag u_flag (
    .clk(clk), .rst_n(rst_n), .open_p(open_p), .close_p(close_p), .q(unlocked)
  );
endmodule

// File: rtl/ulk_checker.sv
module ulk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       unlocked,
  input logic       open_p,
  input logic       close_p
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_closed: assert (!unlocked) else $error("R1 lock set during reset");
    end
  end

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(unlocked));

  a_r3_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(wr_en) && $past(wr_data) == 8'hEE));

  a_r4_close_on_other: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> ($past(wr_en) && $past(wr_data) != 8'hEE));

  a_r3_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_p && close_p));

  a_r8_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (open_p || close_p) |-> wr_en);
endmodule

bind seq_unlock_detect ulk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .unlocked(unlocked), .open_p(open_p), .close_p(close_p)
);

// File: tb/sim_seq_unlock_detect.sv
module sim_seq_unlock_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic unlocked;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seq_unlock_detect u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .unlocked(unlocked)
  );

  localparam logic [7:0] KEY [14] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                                     8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD};

  // Entry = {wr_en, byte, expected unlocked after the edge}
  localparam int NV = 51;
  localparam logic [9:0] VEC [NV] = '{
    // R3: preamble 05,00, key, EE opens
    {1'b1,8'h05,1'b0}, {1'b1,8'h00,1'b0},
    {1'b1,8'hFF,1'b0}, {1'b1,8'h77,1'b0}, {1'b1,8'hB3,1'b0}, {1'b1,8'h51,1'b0},
    {1'b1,8'hA8,1'b0}, {1'b1,8'hD4,1'b0}, {1'b1,8'h62,1'b0}, {1'b1,8'h39,1'b0},
    {1'b1,8'h9C,1'b0}, {1'b1,8'h46,1'b0}, {1'b1,8'h2B,1'b0}, {1'b1,8'h15,1'b0},
    {1'b1,8'h8A,1'b0}, {1'b1,8'hCD,1'b0}, {1'b1,8'hEE,1'b1},
    // R8: idle edge with a zero on the bus
    {1'b0,8'h00,1'b1},
    // R4: preamble 33,00, key, 12 closes
    {1'b1,8'h33,1'b1}, {1'b1,8'h00,1'b1},
    {1'b1,8'hFF,1'b1}, {1'b1,8'h77,1'b1}, {1'b1,8'hB3,1'b1}, {1'b1,8'h51,1'b1},
    {1'b1,8'hA8,1'b1}, {1'b1,8'hD4,1'b1}, {1'b1,8'h62,1'b1}, {1'b1,8'h39,1'b1},
    {1'b1,8'h9C,1'b1}, {1'b1,8'h46,1'b1}, {1'b1,8'h2B,1'b1}, {1'b1,8'h15,1'b1},
    {1'b1,8'h8A,1'b1}, {1'b1,8'hCD,1'b1}, {1'b1,8'h12,1'b0},
    // R7: the closing 12 counts as the nonzero preamble byte
    {1'b1,8'h00,1'b0},
    {1'b1,8'hFF,1'b0}, {1'b1,8'h77,1'b0}, {1'b1,8'hB3,1'b0}, {1'b1,8'h51,1'b0},
    {1'b1,8'hA8,1'b0}, {1'b1,8'hD4,1'b0}, {1'b1,8'h62,1'b0}, {1'b1,8'h39,1'b0},
    {1'b1,8'h9C,1'b0}, {1'b1,8'h46,1'b0}, {1'b1,8'h2B,1'b0}, {1'b1,8'h15,1'b0},
    {1'b1,8'h8A,1'b0}, {1'b1,8'hCD,1'b0}, {1'b1,8'hEE,1'b1}
  };

  task automatic step(input logic en, input logic [7:0] d);
    @(negedge clk);
    wr_en = en;
    wr_data = d;
    @(posedge clk);
    #2;
    wr_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    step(1'b1, d);
  endtask

  task automatic put_key(input int upto);
    for (int k = 0; k < upto; k++) put(KEY[k]);
  endtask

  task automatic expect_lock(input string req, input logic exp);
    checks++;
    if (unlocked !== exp) begin
      fails++;
      $display("FAIL %s unlocked=%b expected=%b", req, unlocked, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    expect_lock("R1 during reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_lock("R1 after reset", 1'b0);

    // Table walk: R3, R4, R7, R8
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8:1]);
      checks++;
      if (unlocked !== VEC[i][0]) begin
        fails++;
        $display("FAIL vec %0d (R3/R4/R7/R8) unlocked=%b expected=%b", i, unlocked, VEC[i][0]);
      end
    end

    // R1: reset while open closes the lock; R2: key with no preamble stays closed
    do_reset();
    expect_lock("R1 reset while open", 1'b0);
    put_key(14); put(8'hEE);
    expect_lock("R2 no preamble", 1'b0);

    // R9: double zero does not arm
    do_reset();
    put(8'h01); put(8'h00); put(8'h00); put_key(14); put(8'hEE);
    expect_lock("R9 double zero", 1'b0);

    // R10: long nonzero prefix is fine
    do_reset();
    put(8'h01); put(8'h02); put(8'h03); put(8'h00); put_key(14); put(8'hEE);
    expect_lock("R10 long prefix", 1'b1);

    // R5: mid-run break while open leaves lock open, even with a stray final byte
    put(8'h01); put(8'h00); put_key(5); put(8'h10);
    for (int k = 5; k < 14; k++) put(KEY[k]);
    put(8'h99);
    expect_lock("R5 abort keeps open", 1'b1);

    // R5: mid-run break while closed leaves lock closed
    do_reset();
    put(8'h01); put(8'h00); put_key(7); put(8'h44);
    for (int k = 7; k < 14; k++) put(KEY[k]);
    put(8'hEE);
    expect_lock("R5 abort keeps closed", 1'b0);

    // R6: zero in mid-run re-arms at once
    do_reset();
    put(8'h01); put(8'h00); put_key(5); put(8'h00); put_key(14); put(8'hEE);
    expect_lock("R6 mid-run rearm", 1'b1);

    // R8: idle edges inside a key run do not disturb the position
    do_reset();
    put(8'h07); put(8'h00); put_key(6);
    step(1'b0, 8'h00); step(1'b0, 8'h55);
    for (int k = 6; k < 14; k++) put(KEY[k]);
    put(8'hEE);
    expect_lock("R8 idle inside run", 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule